// File: doc/BRIEF.md
# Runtime Clock Source Switch Controller

This block picks which of four free-running oscillators drives the system clock: a fast internal RC, a low-power 32 kHz secondary crystal oscillator, a low-power internal RC and a primary oscillator. A static configuration input decides whether software may change the source at run time. The default of this input is 1, which locks the selection to the source named by a static configuration select field.

Software uses a small control interface clocked by `ctl_clk`. A write places a 2-bit code in the request field. If the same write sets the go bit, the block starts a switch. The go bit stays high while the handover is in progress. The current-source status field keeps the old code until the new oscillator actually drives `clk_out`. At that point the status changes and the go bit clears in the same cycle.

The output multiplexer is glitch-free. Each source has its own gating leg. A leg's arm signal is synchronised on that source's rising edges and applied on its falling edges. A leg may arm only once every other leg has been seen off. The output therefore falls with the old clock, stays low, and next rises with a full high phase of the new clock. All ports are plain control and status pins. There is no streaming data path, so no valid/ready handshake applies.

Top module: `clksw_ctrl`

## Requirements
- R1: Source codes are 00 = fast RC, 01 = secondary 32 kHz, 10 = low-power RC, 11 = primary. While reset is held, `cur_src` and `req_src` equal `cfg_src` and `go_bit` is 0.
- R2: While `cfg_switch_n` is 1, writes change neither `req_src` nor `cur_src`. In that state `go_bit` reads 0 even after a write of 1, and `clk_out` keeps the period of the `cfg_src` source.
- R3: `mon_en` equals `cfg_monitor` when `cfg_switch_n` is 0, and is 0 when `cfg_switch_n` is 1.
- R4: With switching enabled, a write with `wr_go`=1 naming a source other than `cur_src` loads `req_src` and sets `go_bit` at the write edge.
- R5: After a switch completes, `go_bit` is 0, `cur_src` equals the requested code, and `clk_out` has that source's period.
- R6: A go write that names the current source drops `go_bit` one `ctl_clk` cycle after the write edge and leaves `cur_src` unchanged.
- R7: While `go_bit` is 1, writes are ignored and `req_src` holds.
- R8: `cur_src` changes only in the cycle in which `go_bit` falls, and never while a switch is still in flight.
- R9: `clk_out` has no runt pulses. Every high phase is a full high phase of one source, and every low phase lasts at least the shortest source half-period. At most one gating leg is enabled at any time.
- R10: With switching enabled, a write with `wr_go`=0 loads `req_src`, leaves `go_bit` at 0, and changes neither `cur_src` nor the `clk_out` period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control and status register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_frc | input | 1 | Fast internal RC clock (code 00) |
| clk_sosc | input | 1 | Secondary 32 kHz clock (code 01) |
| clk_lprc | input | 1 | Low-power internal RC clock (code 10) |
| clk_pri | input | 1 | Primary oscillator clock (code 11) |
| cfg_switch_n | input | 1 | 0 enables runtime switching; 1 (default) locks the source |
| cfg_src | input | 2 | Static source select, used at reset and while locked |
| cfg_monitor | input | 1 | Static request to enable the fail-safe monitor |
| wr_en | input | 1 | Register write strobe |
| wr_src | input | 2 | Requested source code written |
| wr_go | input | 1 | Go bit written |
| req_src | output | 2 | Request field readback |
| go_bit | output | 1 | Switch in progress |
| cur_src | output | 2 | Source currently driving `clk_out` |
| mon_en | output | 1 | Fail-safe monitor enable |
| clk_out | output | 1 | Glitch-free selected system clock |

## Verification
The register fields `req_src` and `go_bit` change at the write edge itself. For a same-source request, `go_bit` returns to 0 one `ctl_clk` edge later. The bench drives at falling edges and samples at the next falling edge, and one edge later again for that case. A real switch has no fixed latency, because it depends on the old and new oscillator rates. The bench therefore polls `go_bit` at each falling edge against a bounded timeout, and only then checks `cur_src` and measures two rising edges of `clk_out`. Runt detection runs throughout, timing every high and low phase of `clk_out` against the source half-periods.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_FRC  = 2'b00,
    SRC_SOSC = 2'b01,
    SRC_LPRC = 2'b10,
    SRC_PRI  = 2'b11
  } src_e;

  function automatic logic [NUM_SRC-1:0] src_onehot(input logic [SEL_W-1:0] code);
    logic [NUM_SRC-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/clksw_leg.sv
module clksw_leg #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic arm,
  output logic en,
  output logic gated
);
  logic arm_sync;

  // arm crosses into this source's domain on rising edges
  clksw_sync #(.WIDTH(1), .STAGES(STAGES)) u_arm_sync (
    .clk   (clk_src),
    .rst_n (rst_n),
    .d     (arm),
    .q     (arm_sync)
  );

  // enable only moves while the source is low, so the AND never chops a phase
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= arm_sync;
  end

  assign gated = clk_src & en;
endmodule

// File: rtl/clksw_regs.sv
module clksw_regs
  import clksw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic [SEL_W-1:0]   cfg_src,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_src,
  input  logic               wr_go,
  input  logic [NUM_SRC-1:0] leg_fb,
  output logic [SEL_W-1:0]   req_src,
  output logic               go_bit,
  output logic [SEL_W-1:0]   cur_src,
  output logic [SEL_W-1:0]   tgt_src
);
  logic [SEL_W-1:0] req_q, cur_q, tgt_q;
  logic             go_q;
  logic             taken;

  // the target leg alone is seen running in this domain
  assign taken = (leg_fb == src_onehot(tgt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= cfg_src;
      cur_q <= cfg_src;
      tgt_q <= cfg_src;
      go_q  <= 1'b0;
    end else if (lock) begin
      go_q  <= 1'b0;
      tgt_q <= cfg_src;
      if (taken) cur_q <= tgt_q;
    end else if (go_q) begin
      if (taken) begin
        cur_q <= tgt_q;
        go_q  <= 1'b0;
      end
    end else if (wr_en) begin
      req_q <= wr_src;
      if (wr_go) begin
        go_q  <= 1'b1;
        tgt_q <= wr_src;
      end
    end
  end

  assign req_src = req_q;
  assign go_bit  = go_q;
  assign cur_src = cur_q;
  assign tgt_src = tgt_q;
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             ctl_clk,
  input  logic             rst_n,
  input  logic             clk_frc,
  input  logic             clk_sosc,
  input  logic             clk_lprc,
  input  logic             clk_pri,
  input  logic             cfg_switch_n,
  input  logic [SEL_W-1:0] cfg_src,
  input  logic             cfg_monitor,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_src,
  input  logic             wr_go,
  output logic [SEL_W-1:0] req_src,
  output logic             go_bit,
  output logic [SEL_W-1:0] cur_src,
  output logic             mon_en,
  output logic             clk_out
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] leg_en;
  logic [NUM_SRC-1:0] leg_arm;
  logic [NUM_SRC-1:0] leg_out;
  logic [NUM_SRC-1:0] leg_fb;
  logic [SEL_W-1:0]   tgt_src;

  // index equals the source code
  assign src_clk = {clk_pri, clk_lprc, clk_sosc, clk_frc};

  clksw_regs u_regs (
    .clk     (ctl_clk),
    .rst_n   (rst_n),
    .lock    (cfg_switch_n),
    .cfg_src (cfg_src),
    .wr_en   (wr_en),
    .wr_src  (wr_src),
    .wr_go   (wr_go),
    .leg_fb  (leg_fb),
    .req_src (req_src),
    .go_bit  (go_bit),
    .cur_src (cur_src),
    .tgt_src (tgt_src)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
    logic others_on;
    assign others_on  = |(leg_en & ~(NUM_SRC'(1) << i));
    assign leg_arm[i] = (tgt_src == SEL_W'(i)) & ~others_on;

    clksw_leg #(.STAGES(SYNC_STAGES)) u_leg (
      .clk_src (src_clk[i]),
      .rst_n   (rst_n),
      .arm     (leg_arm[i]),
      .en      (leg_en[i]),
      .gated   (leg_out[i])
    );
  end

  clksw_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_fb_sync (
    .clk   (ctl_clk),
    .rst_n (rst_n),
    .d     (leg_en),
    .q     (leg_fb)
  );

  assign clk_out = |leg_out;
  assign mon_en  = cfg_monitor & ~cfg_switch_n;
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk
  import clksw_pkg::*;
(
  input logic               ctl_clk,
  input logic               rst_n,
  input logic               cfg_switch_n,
  input logic               go_bit,
  input logic [SEL_W-1:0]   req_src,
  input logic [SEL_W-1:0]   cur_src,
  input logic [NUM_SRC-1:0] leg_en
);
  AST_GO_LOCKED: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    cfg_switch_n |=> !go_bit);  // R2

  AST_REQ_FROZEN: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (go_bit && $past(go_bit)) |-> $stable(req_src));  // R7

  AST_STATUS_AT_DONE: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    !$stable(cur_src) |-> ($fell(go_bit) || cfg_switch_n));  // R8

  AST_ONE_LEG: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    $onehot0(leg_en));  // R9
endmodule

bind clksw_ctrl clksw_ctrl_chk u_chk (
  .ctl_clk      (ctl_clk),
  .rst_n        (rst_n),
  .cfg_switch_n (cfg_switch_n),
  .go_bit       (go_bit),
  .req_src      (req_src),
  .cur_src      (cur_src),
  .leg_en       (leg_en)
);

// File: tb/clksw_ctrl_test.sv
`timescale 1ns/1ps
module clksw_ctrl_test;
  localparam real CLK_PERIOD = 8.0;
  localparam real H_FRC  = 5.0;
  localparam real H_SOSC = 37.0;
  localparam real H_LPRC = 23.0;
  localparam real H_PRI  = 7.0;
  localparam int  WATCHDOG = 150000;

  logic ctl_clk = 0, rst_n = 0;
  logic clk_frc = 0, clk_sosc = 0, clk_lprc = 0, clk_pri = 0;
  logic cfg_switch_n = 1, cfg_monitor = 0;
  logic [1:0] cfg_src = 0;
  logic wr_en = 0, wr_go = 0;
  logic [1:0] wr_src = 0;
  logic [1:0] req_src, cur_src;
  logic go_bit, mon_en, clk_out;

  int checks = 0, errors = 0, runts = 0;

  always #(CLK_PERIOD/2) ctl_clk = ~ctl_clk;
  always #(H_FRC)  clk_frc  = ~clk_frc;
  always #(H_SOSC) clk_sosc = ~clk_sosc;
  always #(H_LPRC) clk_lprc = ~clk_lprc;
  always #(H_PRI)  clk_pri  = ~clk_pri;

  clksw_ctrl uut (
    .ctl_clk(ctl_clk), .rst_n(rst_n),
    .clk_frc(clk_frc), .clk_sosc(clk_sosc), .clk_lprc(clk_lprc), .clk_pri(clk_pri),
    .cfg_switch_n(cfg_switch_n), .cfg_src(cfg_src), .cfg_monitor(cfg_monitor),
    .wr_en(wr_en), .wr_src(wr_src), .wr_go(wr_go),
    .req_src(req_src), .go_bit(go_bit), .cur_src(cur_src),
    .mon_en(mon_en), .clk_out(clk_out)
  );

  function automatic real half_of(input int s);
    case (s)
      0: return H_FRC;
      1: return H_SOSC;
      2: return H_LPRC;
      default: return H_PRI;
    endcase
  endfunction

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  // R9 runt monitor: high phases must be a full source half-period
  realtime t_edge = 0;
  bit armed = 0;
  always @(posedge clk_out or negedge clk_out) begin
    realtime w;
    w = $realtime - t_edge;
    if (clk_out) begin
      if (armed && rst_n && w < H_FRC - 0.01) begin
        runts++;
        $display("FAIL R9 low phase %0t ns, expected >= %0t ns", w, H_FRC);
      end
    end else begin
      if (armed && rst_n && !(near(w, H_FRC) || near(w, H_SOSC) ||
                              near(w, H_LPRC) || near(w, H_PRI))) begin
        runts++;
        $display("FAIL R9 high phase %0t ns, expected one source half-period", w);
      end
    end
    armed = rst_n;
    t_edge = $realtime;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_period(input string tag, input int src);
    realtime t0, t1;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); t1 = $realtime;
    checks++;
    if (!near(t1 - t0, 2.0 * half_of(src))) begin
      errors++;
      $display("FAIL %s period actual %0t expected %0t", tag, t1 - t0, 2.0 * half_of(src));
    end
    @(negedge ctl_clk);
  endtask

  task automatic do_reset(input logic lockv, input logic [1:0] src, input logic mon);
    @(negedge ctl_clk);
    rst_n = 0; cfg_switch_n = lockv; cfg_src = src; cfg_monitor = mon;
    repeat (3) @(negedge ctl_clk);
    chk("R1 cur_src in reset", cur_src, src);
    chk("R1 req_src in reset", req_src, src);
    chk("R1 go_bit in reset", go_bit, 0);
    chk("R3 mon_en", mon_en, mon & ~lockv);
    rst_n = 1;
    repeat (60) @(negedge ctl_clk);
  endtask

  task automatic do_write(input logic [1:0] s, input logic g);
    @(negedge ctl_clk);
    wr_en = 1; wr_src = s; wr_go = g;
    @(negedge ctl_clk);
    wr_en = 0; wr_go = 0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (go_bit && n < 4000) begin
      @(negedge ctl_clk);
      n++;
    end
    chk(tag, go_bit, 0);
  endtask

  logic [1:0] exp_cur;

  task automatic switch_to(input logic [1:0] s);
    do_write(s, 1);
    chk("R4 req_src after go write", req_src, s);
    if (s == exp_cur) begin
      chk("R4 go_bit at write", go_bit, 1);
      @(negedge ctl_clk);
      chk("R6 go_bit clears for same source", go_bit, 0);
      chk("R6 cur_src unchanged", cur_src, exp_cur);
    end else begin
      chk("R4 go_bit set", go_bit, 1);
      chk("R8 cur_src holds old source", cur_src, exp_cur);
      wait_idle("R5 go_bit completes");
      exp_cur = s;
      chk("R5 cur_src after switch", cur_src, exp_cur);
      chk_period("R5 clk_out period", exp_cur);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c10c));

    // locked: every configured source, writes ignored
    for (int k = 0; k < 4; k++) begin
      do_reset(1'b1, 2'(k), 1'b1);
      chk_period("R2 locked clk_out period", k);
      do_write(2'(k + 1), 1);
      chk("R2 go_bit stays 0 when locked", go_bit, 0);
      chk("R2 req_src unchanged when locked", req_src, k);
      repeat (200) @(negedge ctl_clk);
      chk("R2 cur_src unchanged when locked", cur_src, k);
      chk("R3 mon_en off when locked", mon_en, 0);
      chk_period("R2 locked period after write", k);
    end

    // enabled: every ordered pair of sources
    do_reset(1'b0, 2'd3, 1'b1);
    chk("R3 mon_en on when enabled", mon_en, 1);
    exp_cur = 2'd3;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          if (exp_cur != 2'(a)) switch_to(2'(a));
          switch_to(2'(b));
        end
      end
    end
    switch_to(exp_cur);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int r;
      logic [1:0] s, v;
      r = $urandom % 8;
      s = 2'($urandom % 4);
      if (r == 0) begin
        do_write(s, 0);
        chk("R10 req_src loaded", req_src, s);
        chk("R10 go_bit stays 0", go_bit, 0);
        chk("R10 cur_src unchanged", cur_src, exp_cur);
        chk_period("R10 period unchanged", exp_cur);
      end else if (r == 1) begin
        s = 2'((int'(exp_cur) + 1 + ($urandom % 3)) % 4);
        v = 2'((int'(s) + 1) % 4);
        do_write(s, 1);
        do_write(v, 1);
        chk("R7 req_src frozen while busy", req_src, s);
        chk("R8 cur_src held while busy", cur_src, exp_cur);
        wait_idle("R7 busy switch completes");
        exp_cur = s;
        chk("R7 cur_src after busy switch", cur_src, exp_cur);
        chk_period("R7 period after busy switch", exp_cur);
      end else begin
        switch_to(s);
      end
    end

    checks++;
    if (runts != 0) begin
      errors++;
      $display("FAIL R9 runt pulses actual %0d expected 0", runts);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge ctl_clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule